// File: doc/BRIEF.md
# External Interrupt Trigger and Grouping Unit

This unit sits in front of a main interrupt controller and serves twenty external interrupt lines, numbered 4 through 23 of a 24-line space. Every pin passes through a two-flop synchronizer and one history flop. A per-line trigger selector turns the synchronized pin into a set request: rising edge, falling edge, either edge, low level or high level. Set requests are latched in a sticky pending vector. Software clears it by writing ones. A per-line mask decides whether a pending line reaches a parent request.

Two parent requests leave the unit. The low parent covers lines 4 to 7 and the high parent covers lines 8 to 23. A parent stays up as long as any unmasked pending line in its group remains, so software drops it only by clearing the whole group. A separate wake request is formed from pending lines whose wake enable is set. Only lines 4 to 15 may be enabled for wake.

Software reaches the unit through a simple synchronous write port and a combinational read port. The register indices are: 0 to 2 trigger modes, 3 mask, 4 pending, 5 wake enable.

Top module: `eint_group_unit`

## Requirements
- R1: Trigger modes sit in registers 0, 1 and 2, which cover lines 0–7, 8–15 and 16–23. The 3-bit mode of line L is at bit 4*(L mod 8) of register L/8. The fourth bit of each nibble reads as 0, and a written value reads back with only the 3-bit fields kept (writing 0xffffffff reads 0x77777777).
- R2: Mode codes 100 and 101 select rising edge. A 0-to-1 pin change driven before clock edge E0 shows as a pending bit after edge E2 and not after E1. A 1-to-0 change sets nothing.
- R3: Mode codes 010 and 011 select falling edge. A 1-to-0 pin change sets the pending bit, and a 0-to-1 change does not.
- R4: Mode codes 110 and 111 select both edges. Either pin change sets the pending bit.
- R5: Mode 000 is low level and mode 001 is high level. While the synchronized level is active, the pending bit is set. If the bit is cleared while the level is still active, it is set again one edge after the clear.
- R6: Pending (register 4) is write-one-to-clear. Zero bits in a write leave bits unchanged. When a clear and a set hit the same line on the same edge, the clear wins. Pending bits 0–3 always read 0.
- R7: Mask (register 3) holds 1 for masked and 0 for enabled. A masked line still latches pending but does not reach a parent. Unmasking raises the parent one edge after the write. Mask bits 0–3 read 0.
- R8: parent_lo_o is high exactly when an unmasked pending bit among lines 4–7 is set. parent_hi_o does the same for lines 8–23. A parent stays high until the last such bit in its group is cleared.
- R9: Wake enable (register 5) keeps only bits 4–15, so writing all ones reads 0x0000fff0. wake_o is high when a pending line has its wake enable set, regardless of the mask.
- R10: While reset is applied, the unit shows no pending bits, the mask reads 0x00fffff0, trigger modes and wake enable read 0, and both parents and wake_o are low.

Reset (rst) is synchronous and active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 24 | Asynchronous external interrupt pins, bit n is line n |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register index for writes |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 3 | Register index for reads |
| rd_data_o | output | 32 | Combinational read data |
| parent_lo_o | output | 1 | Request for group of lines 4–7 |
| parent_hi_o | output | 1 | Request for group of lines 8–23 |
| wake_o | output | 1 | Wake request from wake-enabled pending lines |

## Verification
A pin change driven between edges appears in the pending register after the third rising edge that follows it: two synchronizer flops, then the pending flop. The bench therefore waits exactly three edges before sampling, and in one case samples one edge earlier to confirm that nothing is there yet. Register writes take effect on the edge that captures them. The parents, wake request and read data follow from registered state without further delay, and a level-mode bit comes back one edge after it is cleared. All sampling happens at falling edges, at those counted points. The sweep covers every line in every mode, with both encodings of each edge code, and computes the expected pending bit and parent from the mode and the direction of the pin change.

// File: rtl/eint_pkg.sv
package eint_pkg;

    localparam int ADDR_W = 3;

    // register indices: trigger-mode registers start at 0
    localparam logic [ADDR_W-1:0] ADDR_MASK = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_PEND = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_WAKE = 3'd5;

    typedef enum logic [2:0] {
        TRIG_LOW,
        TRIG_HIGH,
        TRIG_FALL,
        TRIG_RISE,
        TRIG_BOTH
    } trig_e;

    typedef struct packed {
        logic now;
        logic prev;
    } pin_hist_t;

    function automatic trig_e decode_trig(input logic [2:0] code);
        trig_e m;
        case (code[2:1])
            2'b00:   m = code[0] ? TRIG_HIGH : TRIG_LOW;
            2'b01:   m = TRIG_FALL;
            2'b10:   m = TRIG_RISE;
            default: m = TRIG_BOTH;
        endcase
        return m;
    endfunction

    function automatic logic trig_hit(input trig_e m, input pin_hist_t h);
        logic hit;
        case (m)
            TRIG_LOW:  hit = !h.now;
            TRIG_HIGH: hit = h.now;
            TRIG_FALL: hit = h.prev && !h.now;
            TRIG_RISE: hit = !h.prev && h.now;
            default:   hit = h.prev ^ h.now;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/eint_sync_bank.sv
module eint_sync_bank #(
    parameter int WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins_i,
    output logic [WIDTH-1:0] now_o,
    output logic [WIDTH-1:0] prev_o
);

    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] now_q;
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pins_i;
            now_q  <= meta_q;
            prev_q <= now_q;
        end
    end

    assign now_o  = now_q;
    assign prev_o = prev_q;

endmodule

// File: rtl/eint_trigger.sv
module eint_trigger
    import eint_pkg::*;
(
    input  logic [2:0] code_i,
    input  logic       now_i,
    input  logic       prev_i,
    output trig_e      mode_o,
    output logic       set_o
);

    pin_hist_t hist;

    always_comb begin
        hist.now  = now_i;
        hist.prev = prev_i;
        mode_o    = decode_trig(code_i);
        set_o     = trig_hit(mode_o, hist);
    end

endmodule

// File: rtl/eint_pending.sv
module eint_pending #(
    parameter int NUM_LINES  = 24,
    parameter int FIRST_LINE = 4,
    parameter int SPLIT_LINE = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] set_i,
    input  logic [NUM_LINES-1:0] clr_i,
    input  logic [NUM_LINES-1:0] mask_i,
    output logic [NUM_LINES-1:0] pend_o,
    output logic                 parent_lo_o,
    output logic                 parent_hi_o
);

    localparam logic [NUM_LINES-1:0] VALID =
        {{(NUM_LINES-FIRST_LINE){1'b1}}, {FIRST_LINE{1'b0}}};
    localparam logic [NUM_LINES-1:0] HI_GRP =
        {{(NUM_LINES-SPLIT_LINE){1'b1}}, {SPLIT_LINE{1'b0}}};
    localparam logic [NUM_LINES-1:0] LO_GRP = VALID & ~HI_GRP;

    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] live;

    // clear has priority over a set landing on the same edge
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= (pend_q | set_i) & ~clr_i & VALID;
    end

    assign live        = pend_q & ~mask_i;
    assign pend_o      = pend_q;
    assign parent_lo_o = |(live & LO_GRP);
    assign parent_hi_o = |(live & HI_GRP);

    // R6: a cleared bit is low on the edge after the clear
    a_r6_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (clr_i != '0) |=> ((pend_q & $past(clr_i)) == '0));

    // R6: pending bits only fall through a clear
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((~pend_q & $past(pend_q) & ~$past(clr_i)) == '0));

endmodule

// File: rtl/eint_group_unit.sv
module eint_group_unit
    import eint_pkg::*;
#(
    parameter int NUM_LINES     = 24,
    parameter int FIRST_LINE    = 4,
    parameter int SPLIT_LINE    = 8,
    parameter int LINES_PER_REG = 8,
    parameter int FIELD_W       = 3,
    parameter int STRIDE        = 4,
    parameter int DATA_W        = 32,
    parameter logic [NUM_LINES-1:0] WAKE_ALLOW = 24'h00fff0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] pins_i,
    input  logic                 wr_en_i,
    input  logic [ADDR_W-1:0]    wr_addr_i,
    input  logic [DATA_W-1:0]    wr_data_i,
    input  logic [ADDR_W-1:0]    rd_addr_i,
    output logic [DATA_W-1:0]    rd_data_o,
    output logic                 parent_lo_o,
    output logic                 parent_hi_o,
    output logic                 wake_o
);

    localparam int NUM_CFG = (NUM_LINES + LINES_PER_REG - 1) / LINES_PER_REG;
    localparam logic [NUM_LINES-1:0] VALID =
        {{(NUM_LINES-FIRST_LINE){1'b1}}, {FIRST_LINE{1'b0}}};
    localparam logic [NUM_LINES-1:0] LO_GRP =
        VALID & ~{{(NUM_LINES-SPLIT_LINE){1'b1}}, {SPLIT_LINE{1'b0}}};
    localparam logic [NUM_LINES-1:0] HI_GRP = VALID & ~LO_GRP;

    logic [NUM_LINES-1:0]              now_v, prev_v, set_v, clr_v, pend_v;
    logic [NUM_LINES-1:0]              mask_q, wake_q;
    logic [NUM_LINES-1:0][FIELD_W-1:0] code_v;

    eint_sync_bank #(.WIDTH(NUM_LINES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .now_o  (now_v),
        .prev_o (prev_v)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        localparam int REG_IDX = l / LINES_PER_REG;
        localparam int BIT_OFF = STRIDE * (l % LINES_PER_REG);

        logic [FIELD_W-1:0] code_q;
        trig_e              mode;

        always_ff @(posedge clk) begin
            if (rst)
                code_q <= '0;
            else if (wr_en_i && wr_addr_i == ADDR_W'(REG_IDX))
                code_q <= wr_data_i[BIT_OFF +: FIELD_W];
        end

        assign code_v[l] = code_q;

        eint_trigger u_trig (
            .code_i (code_q),
            .now_i  (now_v[l]),
            .prev_i (prev_v[l]),
            .mode_o (mode),
            .set_o  (set_v[l])
        );

        if (l >= FIRST_LINE) begin : g_chk
            // R5: an active level re-arms the pending bit on the next edge
            a_r5_level_reassert: assert property (@(posedge clk) disable iff (rst)
                (((mode == TRIG_LOW && !now_v[l]) || (mode == TRIG_HIGH && now_v[l]))
                 && !clr_v[l]) |=> pend_v[l]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= VALID;
            wake_q <= '0;
        end else if (wr_en_i) begin
            if (wr_addr_i == ADDR_MASK) mask_q <= wr_data_i[NUM_LINES-1:0] & VALID;
            if (wr_addr_i == ADDR_WAKE) wake_q <= wr_data_i[NUM_LINES-1:0] & VALID & WAKE_ALLOW;
        end
    end

    assign clr_v = (wr_en_i && wr_addr_i == ADDR_PEND) ? (wr_data_i[NUM_LINES-1:0] & VALID) : '0;

    eint_pending #(
        .NUM_LINES  (NUM_LINES),
        .FIRST_LINE (FIRST_LINE),
        .SPLIT_LINE (SPLIT_LINE)
    ) u_pend (
        .clk         (clk),
        .rst         (rst),
        .set_i       (set_v),
        .clr_i       (clr_v),
        .mask_i      (mask_q),
        .pend_o      (pend_v),
        .parent_lo_o (parent_lo_o),
        .parent_hi_o (parent_hi_o)
    );

    assign wake_o = |(pend_v & wake_q);

    always_comb begin
        rd_data_o = '0;
        if (rd_addr_i == ADDR_MASK)
            rd_data_o[NUM_LINES-1:0] = mask_q;
        else if (rd_addr_i == ADDR_PEND)
            rd_data_o[NUM_LINES-1:0] = pend_v;
        else if (rd_addr_i == ADDR_WAKE)
            rd_data_o[NUM_LINES-1:0] = wake_q;
        else if (int'(rd_addr_i) < NUM_CFG) begin
            for (int l = 0; l < NUM_LINES; l++) begin
                if (int'(rd_addr_i) == l / LINES_PER_REG)
                    rd_data_o[STRIDE*(l%LINES_PER_REG) +: FIELD_W] = code_v[l];
            end
        end
    end

    logic unused_wdata;
    assign unused_wdata = ^wr_data_i[DATA_W-1:NUM_LINES];

    // R8: a parent rises only when its pending bits or the mask changed
    a_r8_lo_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(parent_lo_o) |-> (($past(pend_v & LO_GRP) != (pend_v & LO_GRP))
                                || ($past(mask_q) != mask_q)));
    a_r8_hi_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(parent_hi_o) |-> (($past(pend_v & HI_GRP) != (pend_v & HI_GRP))
                                || ($past(mask_q) != mask_q)));

    // R9: wake only ever comes from a line inside the allowed range
    a_r9_wake_source: assert property (@(posedge clk) disable iff (rst)
        wake_o |-> ((pend_v & WAKE_ALLOW) != '0));

endmodule

// File: tb/eint_group_unit_bench.sv
module eint_group_unit_bench;

    localparam logic [2:0] A_MASK = 3'd3;
    localparam logic [2:0] A_PEND = 3'd4;
    localparam logic [2:0] A_WAKE = 3'd5;
    localparam logic [31:0] ALL = 32'h00ffffff;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [23:0] pins = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        parent_lo, parent_hi, wake;

    int checks = 0;
    int errors = 0;
    logic [31:0] cfg_sh [3];

    always #4 clk = ~clk;

    eint_group_unit u_eint_group_unit (
        .clk         (clk),
        .rst         (rst),
        .pins_i      (pins),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .parent_lo_o (parent_lo),
        .parent_hi_o (parent_hi),
        .wake_o      (wake)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic set_code(input int line, input logic [2:0] code);
        cfg_sh[line/8][4*(line%8) +: 4] = {1'b0, code};
        wr(3'(line/8), cfg_sh[line/8]);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        ticks(4);
        // R10: state while reset is held
        rd(A_PEND, v); chk("R10 pend", v, 0);
        rd(A_MASK, v); chk("R10 mask", v, 32'h00fffff0);
        rd(3'd0, v);   chk("R10 cfg0", v, 0);
        rd(A_WAKE, v); chk("R10 wake reg", v, 0);
        chk("R10 outputs", {29'd0, parent_lo, parent_hi, wake}, 0);
        rst = 1'b0;
        ticks(1);

        for (int r = 0; r < 3; r++) begin
            cfg_sh[r] = 32'h44444444;
            wr(3'(r), cfg_sh[r]);
        end
        wr(A_MASK, 0);
        ticks(3);
        wr(A_PEND, ALL);

        // R1: field packing and read-back
        wr(3'd1, 32'hffffffff);
        rd(3'd1, v); chk("R1 cfg1 readback", v, 32'h77777777);
        wr(3'd1, 32'h44444444);
        rd(3'd1, v); chk("R1 cfg1 restore", v, 32'h44444444);
        rd(3'd2, v); chk("R1 cfg2", v, 32'h44444444);
        ticks(3);
        wr(A_PEND, ALL);

        // R2: latency of a rising edge
        pins[6] = 1'b1;
        ticks(2); rd(A_PEND, v); chk("R2 not yet after two edges", v, 0);
        ticks(1); rd(A_PEND, v); chk("R2 set after third edge", v, 32'h40);
        wr(A_PEND, ALL);
        pins[6] = 1'b0;
        ticks(3); rd(A_PEND, v); chk("R2 falling ignored", v, 0);

        // sweep of every line through every mode (R2 R3 R4 R5 R8)
        for (int l = 4; l < 24; l++) begin
            for (int m = 0; m < 5; m++) begin
                logic [2:0] code;
                logic e_up, e_hold, e_dn;
                logic [31:0] bit_l;
                bit_l = 32'd1 << l;
                case (m)
                    0: code = 3'd0;
                    1: code = 3'd1;
                    2: code = 3'd2 | 3'(l & 1);
                    3: code = 3'd4 | 3'(l & 1);
                    default: code = 3'd6 | 3'(l & 1);
                endcase
                e_up   = (m != 2);
                e_hold = (m == 1);
                e_dn   = (m != 3);
                set_code(l, code);
                ticks(3);
                wr(A_PEND, ALL);
                pins[l] = 1'b1;
                ticks(3);
                rd(A_PEND, v);
                chk($sformatf("R2 R3 R4 R5 line %0d code %0d up", l, code), v, e_up ? bit_l : 0);
                chk($sformatf("R8 line %0d code %0d parents", l, code),
                    {30'd0, parent_lo, parent_hi},
                    (l < 8) ? {30'd0, e_up, 1'b0} : {30'd0, 1'b0, e_up});
                wr(A_PEND, ALL);
                ticks(1);
                rd(A_PEND, v);
                chk($sformatf("R5 line %0d code %0d reassert", l, code), v, e_hold ? bit_l : 0);
                wr(A_PEND, ALL);
                pins[l] = 1'b0;
                ticks(3);
                rd(A_PEND, v);
                chk($sformatf("R2 R3 R4 R5 line %0d code %0d down", l, code), v, e_dn ? bit_l : 0);
                set_code(l, 3'd4);
                ticks(3);
            end
        end
        wr(A_PEND, ALL);

        // R6: clear beats a set on the same edge, zero writes do nothing
        pins[12] = 1'b1;
        ticks(2);
        wr(A_PEND, 32'h1000);
        rd(A_PEND, v); chk("R6 clear wins", v, 0);
        ticks(1); rd(A_PEND, v); chk("R6 stays clear", v, 0);
        pins[13] = 1'b1;
        ticks(3);
        wr(A_PEND, 0);
        rd(A_PEND, v); chk("R6 zero write no effect", v, 32'h2000);
        pins[3:0] = 4'hf;
        ticks(3);
        rd(A_PEND, v); chk("R6 low bits read zero", v, 32'h2000);
        chk("R6 low lines no parent_lo", {31'd0, parent_lo}, 0);
        wr(A_PEND, ALL);
        pins = '0;
        ticks(3);

        // R7: masking
        wr(A_MASK, 32'hffffffff);
        rd(A_MASK, v); chk("R7 mask readback", v, 32'h00fffff0);
        wr(A_MASK, 32'h20);
        pins[5] = 1'b1;
        ticks(3);
        rd(A_PEND, v); chk("R7 masked line latches", v, 32'h20);
        chk("R7 masked no parent", {31'd0, parent_lo}, 0);
        wr(A_MASK, 0);
        chk("R7 unmask raises parent", {31'd0, parent_lo}, 1);
        wr(A_PEND, ALL);
        pins[5] = 1'b0;

        // R8: parent held until the whole group is clear
        pins[9] = 1'b1; pins[20] = 1'b1;
        ticks(3);
        chk("R8 hi parent", {31'd0, parent_hi}, 1);
        wr(A_PEND, 32'h200);
        chk("R8 hi parent held", {31'd0, parent_hi}, 1);
        wr(A_PEND, 32'h100000);
        chk("R8 hi parent dropped", {30'd0, parent_lo, parent_hi}, 0);
        pins = '0;
        ticks(3);

        // R9: wake enable range and wake request
        wr(A_WAKE, 32'hffffffff);
        rd(A_WAKE, v); chk("R9 wake readback", v, 32'h0000fff0);
        wr(A_MASK, 32'hffffffff);
        pins[10] = 1'b1;
        ticks(3);
        chk("R9 wake ignores mask", {31'd0, wake}, 1);
        wr(A_PEND, ALL);
        chk("R9 wake drops", {31'd0, wake}, 0);
        wr(A_MASK, 0);
        pins[20] = 1'b1;
        ticks(3);
        chk("R9 no wake above 15", {30'd0, wake, parent_hi}, 1);

        summary();
    end

endmodule